// File: doc/BRIEF.md
# Nested Zero-Overhead Loop Controller

This block sits beside a program sequencer and runs up to four nested hardware loops without spending instructions on branch or counter updates. Each loop slot holds a signed iteration counter, a start address and an "in use" flag. The sequencer presents one command per execution set: set a start address, enable a loop with a count (optionally as a short loop), skip, continue or break. Alongside the command it presents a marker that says the current execution set is the last one of a loop body, and the program counter of that set. The controller answers on the following cycle with a next-PC override and a valid strobe whenever program flow has to change.

Loops may only nest in ascending order, so the loop doing the work is always the highest-numbered slot whose flag is set. Skip, continue and break always act on that loop. Start addresses and jump targets are PC-relative: the command's data field is an offset that is added to the program counter supplied with the command. A command that names any loop other than the one that nesting order allows is rejected. It raises a one-cycle error pulse and changes nothing.

Top module: `lczo_top`

## Requirements
- R1: After reset all loop flags, the short-loop flag, `next_pc_valid` and `cmd_err` are 0, and every counter in `lc_out` reads 0.
- R2: Command code 1 (set start) on loop n loads that slot's start address with `cur_pc + cmd_data`. It is legal only when flag n is clear and either n is 0 or flag n-1 is set.
- R3: Command code 2 (enable) on loop n loads counter n with `cmd_data` and sets flag n. The same legality rule as R2 applies.
- R4: When no command is present (code 0), `set_end` is 1 and the active counter, read as signed, is greater than 1, `next_pc_valid` is 1 on the next cycle with `next_pc` equal to the active start address, and the active counter is one lower.
- R5: When no command is present, `set_end` is 1 and the active counter is at most 1, the active flag clears, no redirect is issued and the counter keeps its value. `set_end` has no effect when no flag is set.
- R6: Command code 4 (skip) on the active loop checks its signed counter. If the counter is at most 0, the controller redirects to `cur_pc + cmd_data` and clears the active flag. Otherwise it does nothing.
- R7: Command code 5 (continue) on the active loop behaves as follows. If the counter is greater than 1, it redirects to the start address and decrements the counter. Otherwise it redirects to `cur_pc + cmd_data`, clears the flag and sets the counter to 0.
- R8: Command code 6 (break) on the active loop redirects to `cur_pc + cmd_data` and clears the active flag.
- R9: Flags stay packed from bit 0 upward. Skip, continue and break are legal only when some flag is set and `cmd_loop` equals the highest set flag.
- R10: An illegal command (a legality rule broken, or code 7) gives `cmd_err` = 1 for exactly the next cycle, with no redirect and no change to any flag, counter or start address.
- R11: Command code 3 (short enable) acts like enable and also sets `short_flag`. `short_flag` clears in the same cycle that the flag of the loop it was set for clears.
- R12: When a command is present, `set_end` in the same cycle is ignored.
- R13: `loop_flags[i]` is the flag of loop i, and `lc_out[32*i +: 32]` is counter i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command code: 0 none, 1 set start, 2 enable, 3 short enable, 4 skip, 5 continue, 6 break, 7 invalid |
| cmd_loop | input | 2 | Loop index named by the command |
| cmd_data | input | 32 | Count for enable; PC offset for set start and jump targets |
| set_end | input | 1 | Current execution set closes a loop body |
| cur_pc | input | 32 | Program counter of the current execution set |
| next_pc | output | 32 | Redirect target, meaningful while `next_pc_valid` is 1 |
| next_pc_valid | output | 1 | Redirect strobe, one cycle after the causing set |
| loop_flags | output | 4 | Per-loop in-use flags |
| short_flag | output | 1 | Short-loop flag |
| lc_out | output | 128 | Live counters, loop i in bits 32*i+31..32*i |
| cmd_err | output | 1 | Illegal-command pulse |

## Verification
The hardest state to reach from the ports is four loops nested at once with their counters still above 1. In that state an enable is illegal because no slot is free, and a continue on loop 3 must land on loop 3's start address rather than on a lower loop's. The random stimulus is biased so that most enables name the next free slot and most loop-end markers arrive while counters are small. As a result, nesting depth rises and falls through all five levels many times. Directed sequences first build the full four-deep stack, then drive the rejected fifth enable, the skip on a zero or negative count, and a command arriving together with a loop-end marker.

// File: rtl/lczo_pkg.sv
package lczo_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SETSA  = 3'd1,
    OP_ENA    = 3'd2,
    OP_ENA_SH = 3'd3,
    OP_SKIP   = 3'd4,
    OP_CONT   = 3'd5,
    OP_BRK    = 3'd6,
    OP_RSVD   = 3'd7
  } lczo_op_e;

endpackage

// File: rtl/lczo_pick.sv
module lczo_pick #(
  parameter int NLOOP = 4,
  parameter int IW    = $clog2(NLOOP)
) (
  input  logic [NLOOP-1:0] flags_i,
  output logic             act_vld_o,
  output logic [IW-1:0]    act_idx_o,
  output logic [NLOOP-1:0] nest_ok_o
);

  // Highest set flag wins: later iterations override earlier ones.
  always_comb begin
    act_vld_o = 1'b0;
    act_idx_o = '0;
    for (int i = 0; i < NLOOP; i++) begin
      if (flags_i[i]) begin
        act_vld_o = 1'b1;
        act_idx_o = IW'(i);
      end
    end
  end

  // A slot may be opened only when free and its parent is in use.
  for (genvar g = 0; g < NLOOP; g++) begin : g_nest
    if (g == 0) begin : g_root
      assign nest_ok_o[g] = !flags_i[g];
    end else begin : g_child
      assign nest_ok_o[g] = !flags_i[g] && flags_i[g-1];
    end
  end

endmodule

// File: rtl/lczo_slot.sv
module lczo_slot #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_sa_i,
  input  logic [AW-1:0] sa_d_i,
  input  logic          ld_lc_i,
  input  logic [CW-1:0] lc_d_i,
  input  logic          set_lf_i,
  input  logic          clr_lf_i,
  output logic [AW-1:0] sa_o,
  output logic [CW-1:0] lc_o,
  output logic          lf_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sa_o <= '0;
      lc_o <= '0;
      lf_o <= 1'b0;
    end else begin
      if (ld_sa_i) sa_o <= sa_d_i;
      if (ld_lc_i) lc_o <= lc_d_i;
      if (set_lf_i)      lf_o <= 1'b1;
      else if (clr_lf_i) lf_o <= 1'b0;
    end
  end

  // R3
  lf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_lf_i && clr_lf_i));

endmodule

// File: rtl/lczo_ctrl.sv
module lczo_ctrl
  import lczo_pkg::*;
#(
  parameter int NLOOP = 4,
  parameter int AW    = 32,
  parameter int CW    = 32,
  parameter int IW    = $clog2(NLOOP)
) (
  input  logic [2:0]       op_i,
  input  logic [IW-1:0]    loop_i,
  input  logic [CW-1:0]    data_i,
  input  logic [AW-1:0]    pc_i,
  input  logic             end_i,
  input  logic [NLOOP-1:0] nest_ok_i,
  input  logic             act_vld_i,
  input  logic [IW-1:0]    act_idx_i,
  input  logic [CW-1:0]    act_lc_i,
  input  logic [AW-1:0]    act_sa_i,
  output logic [NLOOP-1:0] ld_sa_o,
  output logic [NLOOP-1:0] ld_lc_o,
  output logic [NLOOP-1:0] set_lf_o,
  output logic [NLOOP-1:0] clr_lf_o,
  output logic [AW-1:0]    sa_d_o,
  output logic [CW-1:0]    lc_d_o,
  output logic             redir_o,
  output logic [AW-1:0]    redir_pc_o,
  output logic             bad_o,
  output logic             short_o,
  output logic             ev_end_jump_o,
  output logic             ev_end_done_o
);

  // Counter still has iterations to run after this pass.
  function automatic logic lc_repeat(input logic [CW-1:0] v);
    return $signed(v) > 1;
  endfunction

  // Counter holds no work at all (zero or negative).
  function automatic logic lc_spent(input logic [CW-1:0] v);
    return $signed(v) < 1;
  endfunction

  function automatic logic [CW-1:0] lc_less(input logic [CW-1:0] v);
    return v - CW'(1);
  endfunction

  function automatic logic [AW-1:0] rel_addr(input logic [AW-1:0] pc,
                                             input logic [CW-1:0] off);
    return pc + AW'(off);
  endfunction

  logic          do_sa, do_lc, do_set, do_clr;
  logic [IW-1:0] sel;
  logic          on_active;

  assign on_active = act_vld_i && (loop_i == act_idx_i);
  assign sa_d_o    = rel_addr(pc_i, data_i);

  always_comb begin
    do_sa         = 1'b0;
    do_lc         = 1'b0;
    do_set        = 1'b0;
    do_clr        = 1'b0;
    sel           = act_idx_i;
    lc_d_o        = '0;
    redir_o       = 1'b0;
    redir_pc_o    = '0;
    bad_o         = 1'b0;
    short_o       = 1'b0;
    ev_end_jump_o = 1'b0;
    ev_end_done_o = 1'b0;
    case (op_i)
      OP_NONE: begin
        if (end_i && act_vld_i) begin
          if (lc_repeat(act_lc_i)) begin
            redir_o       = 1'b1;
            redir_pc_o    = act_sa_i;
            do_lc         = 1'b1;
            lc_d_o        = lc_less(act_lc_i);
            ev_end_jump_o = 1'b1;
          end else begin
            do_clr        = 1'b1;
            ev_end_done_o = 1'b1;
          end
        end
      end
      OP_SETSA: begin
        if (nest_ok_i[loop_i]) begin
          sel   = loop_i;
          do_sa = 1'b1;
        end else begin
          bad_o = 1'b1;
        end
      end
      OP_ENA, OP_ENA_SH: begin
        if (nest_ok_i[loop_i]) begin
          sel     = loop_i;
          do_lc   = 1'b1;
          lc_d_o  = data_i;
          do_set  = 1'b1;
          short_o = (op_i == OP_ENA_SH);
        end else begin
          bad_o = 1'b1;
        end
      end
      OP_SKIP: begin
        if (!on_active) begin
          bad_o = 1'b1;
        end else if (lc_spent(act_lc_i)) begin
          redir_o    = 1'b1;
          redir_pc_o = rel_addr(pc_i, data_i);
          do_clr     = 1'b1;
        end
      end
      OP_CONT: begin
        if (!on_active) begin
          bad_o = 1'b1;
        end else if (lc_repeat(act_lc_i)) begin
          redir_o    = 1'b1;
          redir_pc_o = act_sa_i;
          do_lc      = 1'b1;
          lc_d_o     = lc_less(act_lc_i);
        end else begin
          redir_o    = 1'b1;
          redir_pc_o = rel_addr(pc_i, data_i);
          do_lc      = 1'b1;
          lc_d_o     = '0;
          do_clr     = 1'b1;
        end
      end
      OP_BRK: begin
        if (!on_active) begin
          bad_o = 1'b1;
        end else begin
          redir_o    = 1'b1;
          redir_pc_o = rel_addr(pc_i, data_i);
          do_clr     = 1'b1;
        end
      end
      default: bad_o = 1'b1;
    endcase
  end

  // One-hot fan-out of the shared write strobes to the selected slot.
  for (genvar g = 0; g < NLOOP; g++) begin : g_dec
    logic hit;
    assign hit         = (sel == IW'(g));
    assign ld_sa_o[g]  = do_sa  && hit;
    assign ld_lc_o[g]  = do_lc  && hit;
    assign set_lf_o[g] = do_set && hit;
    assign clr_lf_o[g] = do_clr && hit;
  end

endmodule

// File: rtl/lczo_top.sv
module lczo_top #(
  parameter int NLOOP = 4,
  parameter int AW    = 32,
  parameter int CW    = 32,
  parameter int IW    = $clog2(NLOOP)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cmd_op,
  input  logic [IW-1:0]       cmd_loop,
  input  logic [CW-1:0]       cmd_data,
  input  logic                set_end,
  input  logic [AW-1:0]       cur_pc,
  output logic [AW-1:0]       next_pc,
  output logic                next_pc_valid,
  output logic [NLOOP-1:0]    loop_flags,
  output logic                short_flag,
  output logic [NLOOP*CW-1:0] lc_out,
  output logic                cmd_err
);

  logic [CW-1:0]    lc_arr [NLOOP];
  logic [AW-1:0]    sa_arr [NLOOP];
  logic             act_vld;
  logic [IW-1:0]    act_idx;
  logic [NLOOP-1:0] nest_ok;
  logic [CW-1:0]    act_lc;
  logic [AW-1:0]    act_sa;
  logic [NLOOP-1:0] ld_sa, ld_lc, set_lf, clr_lf;
  logic [AW-1:0]    sa_d;
  logic [CW-1:0]    lc_d;
  logic             redir, bad, short_set;
  logic [AW-1:0]    redir_pc;
  logic             ev_end_jump, ev_end_done;
  logic [IW-1:0]    short_idx;

  lczo_pick #(.NLOOP(NLOOP), .IW(IW)) u_pick (
    .flags_i   (loop_flags),
    .act_vld_o (act_vld),
    .act_idx_o (act_idx),
    .nest_ok_o (nest_ok)
  );

  assign act_lc = lc_arr[act_idx];
  assign act_sa = sa_arr[act_idx];

  lczo_ctrl #(.NLOOP(NLOOP), .AW(AW), .CW(CW), .IW(IW)) u_ctrl (
    .op_i          (cmd_op),
    .loop_i        (cmd_loop),
    .data_i        (cmd_data),
    .pc_i          (cur_pc),
    .end_i         (set_end),
    .nest_ok_i     (nest_ok),
    .act_vld_i     (act_vld),
    .act_idx_i     (act_idx),
    .act_lc_i      (act_lc),
    .act_sa_i      (act_sa),
    .ld_sa_o       (ld_sa),
    .ld_lc_o       (ld_lc),
    .set_lf_o      (set_lf),
    .clr_lf_o      (clr_lf),
    .sa_d_o        (sa_d),
    .lc_d_o        (lc_d),
    .redir_o       (redir),
    .redir_pc_o    (redir_pc),
    .bad_o         (bad),
    .short_o       (short_set),
    .ev_end_jump_o (ev_end_jump),
    .ev_end_done_o (ev_end_done)
  );

  for (genvar g = 0; g < NLOOP; g++) begin : g_slot
    lczo_slot #(.AW(AW), .CW(CW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_sa_i  (ld_sa[g]),
      .sa_d_i   (sa_d),
      .ld_lc_i  (ld_lc[g]),
      .lc_d_i   (lc_d),
      .set_lf_i (set_lf[g]),
      .clr_lf_i (clr_lf[g]),
      .sa_o     (sa_arr[g]),
      .lc_o     (lc_arr[g]),
      .lf_o     (loop_flags[g])
    );
    assign lc_out[g*CW +: CW] = lc_arr[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc_valid <= 1'b0;
      next_pc       <= '0;
      cmd_err       <= 1'b0;
      short_flag    <= 1'b0;
      short_idx     <= '0;
    end else begin
      next_pc_valid <= redir;
      if (redir) next_pc <= redir_pc;
      cmd_err <= bad;
      if (short_set) begin
        short_flag <= 1'b1;
        short_idx  <= cmd_loop;
      end else if (short_flag && clr_lf[short_idx]) begin
        short_flag <= 1'b0;
      end
    end
  end

  logic [NLOOP:0] flags_inc;
  assign flags_inc = {1'b0, loop_flags} + (NLOOP+1)'(1);

  // R9
  flags_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(flags_inc));

  // R10
  err_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> ($stable(loop_flags) && !next_pc_valid));

  // R11
  short_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_flag |-> loop_flags[short_idx]);

  // R4
  end_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end_jump |=> (next_pc_valid && act_lc == $past(act_lc) - CW'(1)));

  // R5
  end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_end_done |=> (!next_pc_valid &&
                     $countones(loop_flags) == $countones($past(loop_flags)) - 1));

endmodule

// File: tb/tb_lczo_top.sv
module tb_lczo_top;

  localparam int NL = 4;
  localparam logic [2:0] C_NONE = 3'd0, C_SA = 3'd1, C_EN = 3'd2, C_ENS = 3'd3,
                         C_SKIP = 3'd4, C_CONT = 3'd5, C_BRK = 3'd6, C_BAD = 3'd7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd_op = C_NONE;
  logic [1:0]    cmd_loop = '0;
  logic [31:0]   cmd_data = '0;
  logic          set_end = 1'b0;
  logic [31:0]   cur_pc = '0;
  logic [31:0]   next_pc;
  logic          next_pc_valid;
  logic [3:0]    loop_flags;
  logic          short_flag;
  logic [127:0]  lc_out;
  logic          cmd_err;

  always #2 clk = ~clk;

  lczo_top dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_loop(cmd_loop),
    .cmd_data(cmd_data), .set_end(set_end), .cur_pc(cur_pc),
    .next_pc(next_pc), .next_pc_valid(next_pc_valid), .loop_flags(loop_flags),
    .short_flag(short_flag), .lc_out(lc_out), .cmd_err(cmd_err)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m_lc [NL];
  logic [31:0] m_sa [NL];
  logic [3:0]  m_lf;
  logic        m_sh;
  int          m_sidx;
  logic        e_vld, e_err;
  logic [31:0] e_pc;

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_act();
    int a = -1;
    for (int i = 0; i < NL; i++) if (m_lf[i]) a = i;
    return a;
  endfunction

  function automatic bit m_free(input int n);
    return !m_lf[n] && (n == 0 || m_lf[n-1]);
  endfunction

  function automatic int m_depth();
    int c = 0;
    for (int i = 0; i < NL; i++) if (m_lf[i]) c++;
    return c;
  endfunction

  task automatic m_drop(input int a);
    m_lf[a] = 1'b0;
    if (m_sh && m_sidx == a) m_sh = 1'b0;
  endtask

  // Reference behaviour written from the requirement text.
  task automatic model_step(input logic [2:0] op, input int n, input logic [31:0] d,
                            input logic le, input logic [31:0] p);
    int a = m_act();
    bit legal_act = (a >= 0) && (n == a);
    e_vld = 0; e_err = 0; e_pc = '0;
    case (op)
      C_NONE: if (le && a >= 0) begin               // R4 R5 R12
        if ($signed(m_lc[a]) > 1) begin
          e_vld = 1; e_pc = m_sa[a]; m_lc[a] = m_lc[a] - 1;
        end else m_drop(a);
      end
      C_SA: if (m_free(n)) m_sa[n] = p + d; else e_err = 1;       // R2
      C_EN, C_ENS: if (m_free(n)) begin                            // R3 R11
        m_lc[n] = d; m_lf[n] = 1'b1;
        if (op == C_ENS) begin m_sh = 1'b1; m_sidx = n; end
      end else e_err = 1;
      C_SKIP: if (!legal_act) e_err = 1;                           // R6
        else if ($signed(m_lc[a]) <= 0) begin e_vld = 1; e_pc = p + d; m_drop(a); end
      C_CONT: if (!legal_act) e_err = 1;                           // R7
        else if ($signed(m_lc[a]) > 1) begin
          e_vld = 1; e_pc = m_sa[a]; m_lc[a] = m_lc[a] - 1;
        end else begin
          e_vld = 1; e_pc = p + d; m_drop(a); m_lc[a] = '0;
        end
      C_BRK: if (!legal_act) e_err = 1;                            // R8
        else begin e_vld = 1; e_pc = p + d; m_drop(a); end
      default: e_err = 1;                                          // R10
    endcase
  endtask

  task automatic run_op(input logic [2:0] op, input int n, input logic [31:0] d,
                        input logic le, input logic [31:0] p, input string req);
    logic [127:0] exp_lc;
    cmd_op = op; cmd_loop = 2'(n); cmd_data = d; set_end = le; cur_pc = p;
    model_step(op, n, d, le, p);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NL; i++) exp_lc[i*32 +: 32] = m_lc[i];
    check(cmd_err == e_err, {"R10 err ", req}, 128'(cmd_err), 128'(e_err));
    check(next_pc_valid == e_vld, {"valid ", req}, 128'(next_pc_valid), 128'(e_vld));
    if (e_vld) check(next_pc == e_pc, {"target ", req}, 128'(next_pc), 128'(e_pc));
    check(loop_flags == m_lf, {"R9 R13 flags ", req}, 128'(loop_flags), 128'(m_lf));
    check(short_flag == m_sh, {"R11 short ", req}, 128'(short_flag), 128'(m_sh));
    check(lc_out == exp_lc, {"R13 counters ", req}, lc_out, exp_lc);
    cmd_op = C_NONE; set_end = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NL; i++) begin m_lc[i] = '0; m_sa[i] = '0; end
    m_lf = '0; m_sh = 1'b0; m_sidx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(loop_flags == 4'b0, "R1 flags", 128'(loop_flags), 128'(0));
    check(short_flag == 1'b0, "R1 short", 128'(short_flag), 128'(0));
    check(next_pc_valid == 1'b0, "R1 valid", 128'(next_pc_valid), 128'(0));
    check(cmd_err == 1'b0, "R1 err", 128'(cmd_err), 128'(0));
    check(lc_out == '0, "R1 counters", lc_out, 128'(0));

    // R2 R3 R4 R5: three-pass loop 0
    run_op(C_SA, 0, 32'd4, 0, 32'h100, "R2 set start");
    run_op(C_EN, 0, 32'd3, 0, 32'h108, "R3 enable");
    run_op(C_NONE, 0, 0, 1, 32'h120, "R4 end pass1");
    run_op(C_NONE, 0, 0, 1, 32'h120, "R4 end pass2");
    run_op(C_NONE, 0, 0, 1, 32'h120, "R5 end last");
    run_op(C_NONE, 0, 0, 1, 32'h120, "R5 end idle");
    // R6 skip on zero and on negative count, not on positive
    run_op(C_EN, 0, 32'd0, 0, 32'h200, "R3 enable zero");
    run_op(C_SKIP, 0, 32'h40, 0, 32'h204, "R6 skip zero");
    run_op(C_EN, 0, 32'hFFFF_FFFE, 0, 32'h300, "R3 enable neg");
    run_op(C_SKIP, 0, 32'h10, 0, 32'h304, "R6 skip neg");
    run_op(C_EN, 0, 32'd2, 0, 32'h400, "R3 enable two");
    run_op(C_SKIP, 0, 32'h10, 0, 32'h404, "R6 skip kept");
    // R9 R10 build four deep, reject fifth and wrong-loop commands
    run_op(C_SA, 1, 32'd8, 0, 32'h500, "R2 start1");
    run_op(C_EN, 1, 32'd5, 0, 32'h504, "R3 en1");
    run_op(C_EN, 3, 32'd5, 0, 32'h508, "R10 skip level");
    run_op(C_SA, 2, 32'd8, 0, 32'h600, "R2 start2");
    run_op(C_ENS, 2, 32'd4, 0, 32'h604, "R11 short en2");
    run_op(C_SA, 3, 32'd12, 0, 32'h700, "R2 start3");
    run_op(C_EN, 3, 32'd3, 0, 32'h704, "R3 en3");
    run_op(C_EN, 0, 32'd3, 0, 32'h708, "R10 full");
    run_op(C_CONT, 1, 32'h20, 0, 32'h70C, "R9 wrong level");
    run_op(C_BAD, 3, 32'h20, 0, 32'h70C, "R10 code7");
    run_op(C_CONT, 3, 32'h20, 0, 32'h710, "R7 cont repeat");
    run_op(C_CONT, 3, 32'h20, 1, 32'h714, "R7 R12 cont with end");
    run_op(C_CONT, 3, 32'h20, 0, 32'h718, "R7 cont exit");
    run_op(C_BRK, 2, 32'h30, 0, 32'h800, "R8 R11 break short");
    run_op(C_NONE, 0, 0, 1, 32'h900, "R4 end on loop1");
    run_op(C_BRK, 1, 32'h4, 0, 32'h904, "R8 break1");
    run_op(C_BRK, 0, 32'h4, 0, 32'h908, "R8 break0");
    run_op(C_SKIP, 0, 32'h4, 0, 32'h90C, "R9 no active");

    // Random mix biased toward legal nesting
    for (int it = 0; it < 3000; it++) begin
      int r = int'($urandom % 100);
      int a = m_act();
      int nx = m_depth();
      logic [31:0] p = $urandom;
      logic [31:0] d = 32'($urandom % 64);
      logic le = 1'($urandom % 2);
      logic [31:0] cnt = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : 32'($urandom % 5);
      int nl = (nx < NL) ? nx : int'($urandom % NL);
      int na = (a >= 0) ? a : 0;
      if (r < 14)      run_op(C_SA, nl, d, le, p, "R2 rnd");
      else if (r < 30) run_op(C_EN, nl, cnt, le, p, "R3 rnd");
      else if (r < 36) run_op(C_ENS, nl, cnt, le, p, "R11 rnd");
      else if (r < 64) run_op(C_NONE, 0, d, 1'b1, p, "R4 R5 rnd");
      else if (r < 72) run_op(C_SKIP, na, d, le, p, "R6 rnd");
      else if (r < 80) run_op(C_CONT, na, d, le, p, "R7 rnd");
      else if (r < 85) run_op(C_BRK, na, d, le, p, "R8 rnd");
      else if (r < 93) run_op(3'($urandom % 8), int'($urandom % NL), d, le, p, "R10 rnd");
      else             run_op(C_NONE, 0, d, 1'b0, p, "R12 idle rnd");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule